// File: doc/BRIEF.md
# Periodic Interval Timer

This block produces a regular time base for system software. A free-running divider turns the master clock into a slow counting tick, one tick every sixteen master-clock cycles. A 20-bit position counter steps on each tick from zero up to a programmed limit and then starts again at zero. Each such return to zero ends one period: it raises a pending flag, it advances a 12-bit count of finished periods, and, when unmasked, it drives a level-sensitive interrupt request.

Software talks to the timer over a small synchronous register bus. One register holds the limit, a run bit and an interrupt-mask bit. A second register shows the pending flag. The position and the period count are visible through two read views. The acknowledging view clears the pending flag and the period count as it is read. The observing view changes nothing, so any agent can sample elapsed time without disturbing the owner of the interrupt. Clearing the run bit does not stop the timer at once. It finishes the period in progress and then parks at zero.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset every register reads as zero, the interrupt output is low and the timer is stopped.
- R2: Byte offset 0x00 is the control register: limit in bits 19:0, run bit 24, interrupt-mask bit 25, all other bits reading 0. Writes to any other offset have no effect. A read returns its data on the clock edge that samples the read strobe, reflecting the state just before that edge. Offsets without a register read as 0.
- R3: While running, the position advances once every 16 clock cycles. It first reads 1 sixteen cycles after the edge that captured the enabling write.
- R4: The position runs 0, 1, …, limit and then returns to 0, so one period spans limit+1 ticks (limit 0 gives one tick per period).
- R5: Every return of the position to 0 sets the pending flag and adds 1 to the 12-bit period count, which wraps modulo 4096.
- R6: A read at offset 0x08 returns the period count in bits 31:20 and the position in bits 19:0, then clears the pending flag and the period count.
- R7: A read at offset 0x0C returns the same fields as offset 0x08 and changes no state.
- R8: Offset 0x04 reads the pending flag in bit 0. Reading it, or rewriting the control register, leaves the flag unchanged.
- R9: With the run bit cleared, counting continues until the position returns to 0 (a completed period that is counted), then holds there. If the position is already 0, counting stops at once. Setting the run bit again resumes from 0.
- R10: The interrupt output is high exactly when the pending flag and the interrupt-mask bit are both set.
- R11: When a period ends on the same edge as an acknowledging read, the period count becomes 1 and the pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded properties assume the bus issues at most one access per cycle and that the limit stays constant while a period is running, so the position only ever steps by one or returns to zero. The stimulus reprograms the limit only after a reset or after the timer has parked at zero, and any mid-run control writes keep the same limit. It spaces reads so that each one stands alone. Expected register contents are derived from the number of sixteen-cycle ticks elapsed since the enabling write and from the completion count at the last acknowledging read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned OFS_CTRL  = 0;
    localparam int unsigned OFS_FLAG  = 4;
    localparam int unsigned OFS_ACK   = 8;
    localparam int unsigned OFS_PEEK  = 12;
    localparam int unsigned RUN_POS   = 24;
    localparam int unsigned MASK_POS  = 25;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ps_t;

    ps_t ps_q, ps_d;

    always_comb begin
        ps_d = ps_q;
        if (!run_i || ps_q.cnt == LAST) begin
            ps_d.cnt = '0;
        end else begin
            ps_d.cnt = ps_q.cnt + 1'b1;
        end
    end

    assign tick_o = run_i && (ps_q.cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    // independent spacing monitor for the tick stream
    logic [CW:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap_q <= '0;
        else if (!run_i || tick_o) gap_q <= '0;
        else                       gap_q <= gap_q + 1'b1;
    end

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> gap_q == (CW+1)'(DIV - 1))
        else $error("tick spacing broken");
endmodule

// File: rtl/tmr_period_core.sv
module tmr_period_core #(
    parameter int unsigned VAL_W = 20,
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic [VAL_W-1:0] limit_i,
    input  logic             ack_i,
    output logic [VAL_W-1:0] pos_o,
    output logic [CNT_W-1:0] laps_o,
    output logic             flag_o,
    output logic             active_o
);
    typedef struct packed {
        logic [VAL_W-1:0] pos;
        logic [CNT_W-1:0] laps;
        logic             flag;
    } core_t;

    core_t c_q, c_d;
    logic  lap_end;

    assign lap_end = tick_i && (c_q.pos >= limit_i);

    always_comb begin
        c_d = c_q;
        if (tick_i) begin
            c_d.pos = lap_end ? '0 : c_q.pos + 1'b1;
        end
        if (ack_i) begin
            c_d.laps = lap_end ? CNT_W'(1) : '0;
        end else if (lap_end) begin
            c_d.laps = c_q.laps + 1'b1;
        end
        if (lap_end)    c_d.flag = 1'b1;
        else if (ack_i) c_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pos_o    = c_q.pos;
    assign laps_o   = c_q.laps;
    assign flag_o   = c_q.flag;
    assign active_o = run_i || (c_q.pos != '0);

    assert_pos_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (pos_o == '0) || (pos_o == $past(pos_o) + 1'b1))
        else $error("position moved by more than one");

    assert_wrap_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pos_o) != '0 && pos_o == '0) |-> flag_o)
        else $error("period ended without pending flag");

    assert_lap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (laps_o != $past(laps_o)) |-> (laps_o == $past(laps_o) + 1'b1 || laps_o <= CNT_W'(1)))
        else $error("period count jumped");

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack_i) && !flag_o) |-> laps_o == '0)
        else $error("acknowledge left a period count");

    assert_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && pos_o == '0) |=> pos_o == '0)
        else $error("stopped timer moved");
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned VAL_W  = 20,
    parameter int unsigned CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic [VAL_W-1:0]  pos_i,
    input  logic [CNT_W-1:0]  laps_i,
    input  logic              flag_i,
    output logic [VAL_W-1:0]  limit_o,
    output logic              run_o,
    output logic              mask_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [VAL_W-1:0]  limit;
        logic              run;
        logic              mask;
        logic [DATA_W-1:0] rdata;
    } reg_t;

    reg_t r_q, r_d;
    logic sel_ctrl, sel_flag, sel_ack, sel_peek;
    logic [DATA_W-1:0] rd_val;
    logic unused_wdata;

    assign sel_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
    assign sel_flag = (addr_i == ADDR_W'(OFS_FLAG));
    assign sel_ack  = (addr_i == ADDR_W'(OFS_ACK));
    assign sel_peek = (addr_i == ADDR_W'(OFS_PEEK));
    assign unused_wdata = ^wdata_i;

    always_comb begin
        rd_val = '0;
        if (sel_ctrl) begin
            rd_val[VAL_W-1:0] = r_q.limit;
            rd_val[RUN_POS]   = r_q.run;
            rd_val[MASK_POS]  = r_q.mask;
        end else if (sel_flag) begin
            rd_val[0] = flag_i;
        end else if (sel_ack || sel_peek) begin
            rd_val[VAL_W-1:0]       = pos_i;
            rd_val[VAL_W +: CNT_W]  = laps_i;
        end
    end

    always_comb begin
        r_d = r_q;
        if (wr_i && sel_ctrl) begin
            r_d.limit = wdata_i[VAL_W-1:0];
            r_d.run   = wdata_i[RUN_POS];
            r_d.mask  = wdata_i[MASK_POS];
        end
        if (rd_i) r_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign limit_o = r_q.limit;
    assign run_o   = r_q.run;
    assign mask_o  = r_q.mask;
    assign ack_o   = rd_i && sel_ack;
    assign rdata_o = r_q.rdata;

    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_i) |-> $stable({limit_o, run_o, mask_o}))
        else $error("control changed without a write");
endmodule

// File: rtl/interval_tick_timer.sv
module interval_tick_timer #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned VAL_W  = 20,
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned PRESC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [VAL_W-1:0] limit;
    logic             run, mask, ack, tick, active, flag;
    logic [VAL_W-1:0] pos;
    logic [CNT_W-1:0] laps;

    tmr_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VAL_W(VAL_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
        .wdata_i(bus_wdata), .rd_i(bus_rd), .pos_i(pos), .laps_i(laps),
        .flag_i(flag), .limit_o(limit), .run_o(run), .mask_o(mask),
        .ack_o(ack), .rdata_o(bus_rdata)
    );

    tmr_prescaler #(.DIV(PRESC)) u_presc (
        .clk(clk), .rst_n(rst_n), .run_i(active), .tick_o(tick)
    );

    tmr_period_core #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run),
        .limit_i(limit), .ack_i(ack), .pos_o(pos), .laps_o(laps),
        .flag_o(flag), .active_o(active)
    );

    assign irq = flag & mask;

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask && flag))
        else $error("interrupt without mask and flag");

    assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && $stable(mask) && !$past(ack)) |-> irq)
        else $error("interrupt dropped without acknowledge");
endmodule

// File: tb/interval_tick_timer_bench.sv
`timescale 1ns/1ps
module interval_tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    interval_tick_timer u_interval_tick_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [3:0] A_CTRL = 4'h0, A_FLAG = 4'h4, A_ACK = 4'h8, A_PEEK = 4'hC;
    localparam logic [31:0] RUN = 32'h0100_0000, MASK = 32'h0200_0000;

    always @(posedge clk) begin
        if (cyc == 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // model: enable edge, limit, completions removed by the last acknowledge
    longint m_e;
    int     m_p;
    longint m_base;

    function automatic longint ticks(longint n);
        return (n >= m_e) ? (n - m_e) / 16 : 0;
    endfunction
    function automatic longint comps(longint n);
        return ticks(n) / (m_p + 1) - m_base;
    endfunction
    function automatic logic [31:0] img(longint n);
        logic [11:0] pc;
        logic [19:0] cur;
        pc  = 12'(comps(n) % 4096);
        cur = 20'(ticks(n) % (m_p + 1));
        return {pc, cur};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_base = 0; m_e = 0; m_p = 0;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, output longint e);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        e = cyc; bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d, output longint r);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        r = cyc; bus_rd = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic wait_to(input longint t);
        while (cyc < t - 1) @(negedge clk);
    endtask

    logic [31:0] d;
    longint r, e, dd;
    int offs [8] = '{3, 16, 17, 33, 50, 100, 161, 300};

    initial begin
        do_reset();
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        bus_read(A_PEEK, d, r); check("R1 image", d, 32'h0);
        bus_read(A_FLAG, d, r); check("R1 flag", d, 32'h0);
        bus_read(A_CTRL, d, r); check("R1 ctrl", d, 32'h0);

        // R2 control register, ignored writes, unmapped read
        bus_write(A_PEEK, 32'hFFFF_FFFF, e);
        bus_write(A_FLAG, 32'hFFFF_FFFF, e);
        bus_write(A_ACK,  32'hFFFF_FFFF, e);
        bus_read(A_CTRL, d, r); check("R2 ignored writes ctrl", d, 32'h0);
        repeat (40) @(negedge clk);
        bus_read(A_PEEK, d, r); check("R2 ignored writes image", d, 32'h0);
        bus_write(A_CTRL, 32'hFFFF_FFFF, e);
        bus_read(A_CTRL, d, r); check("R2 ctrl fields", d, 32'h030F_FFFF);
        bus_read(4'h2, d, r); check("R2 unmapped", d, 32'h0);

        // R3 R4 R5 R7 sweep over small limits
        for (int p = 0; p < 5; p++) begin
            do_reset();
            bus_write(A_CTRL, RUN | 32'(p), e);
            m_e = e; m_p = p;
            for (int i = 0; i < 8; i++) begin
                wait_to(e + offs[i]);
                bus_read(A_PEEK, d, r); check("R3 R4 R7 image", d, img(r - 1));
                bus_read(A_FLAG, d, r); check("R5 R8 flag", d, {31'b0, comps(r - 1) > 0});
            end
        end

        // R6 R11 R10 R8 acknowledge behaviour, limit 2, mask on
        do_reset();
        bus_write(A_CTRL, RUN | MASK | 32'd2, e);
        m_e = e; m_p = 2;
        wait_to(e + 1 + 16*7 + 5);
        bus_read(A_ACK, d, r); check("R6 ack read", d, img(r - 1));
        m_base = ticks(r - 1) / 3;
        bus_read(A_PEEK, d, r); check("R6 cleared", d, img(r - 1));
        check("R10 irq after ack", {31'b0, irq}, {31'b0, comps(cyc) > 0});
        wait_to(e + 16*9);
        bus_read(A_ACK, d, r); check("R11 ack read", d, img(r - 1));
        m_base = ticks(r - 1) / 3;
        bus_read(A_PEEK, d, r); check("R11 count one", d, 32'h0010_0000);
        bus_read(A_FLAG, d, r); check("R11 flag kept", d, 32'h1);
        check("R10 irq high", {31'b0, irq}, 32'h1);
        bus_write(A_CTRL, RUN | 32'd2, dd);
        check("R10 masked", {31'b0, irq}, 32'h0);
        bus_read(A_FLAG, d, r); check("R8 flag after ctrl write", d, 32'h1);
        bus_read(A_FLAG, d, r); check("R8 flag reread", d, 32'h1);
        bus_write(A_CTRL, RUN | MASK | 32'd2, dd);
        check("R10 unmasked", {31'b0, irq}, {31'b0, comps(cyc) > 0});
        bus_read(A_ACK, d, r); check("R6 ack read 2", d, img(r - 1));
        m_base = ticks(r - 1) / 3;
        check("R10 irq after ack 2", {31'b0, irq}, {31'b0, comps(cyc) > 0});

        // R9 run-on after disable, limit 5
        do_reset();
        bus_write(A_CTRL, RUN | 32'd5, e);
        m_e = e; m_p = 5;
        wait_to(e + 16*8 + 3);
        bus_write(A_CTRL, 32'd5, dd);
        wait_to(e + 162);
        bus_read(A_PEEK, d, r); check("R9 still counting", d, img(r - 1));
        wait_to(e + 400);
        bus_read(A_PEEK, d, r); check("R9 parked", d, 32'h0020_0000);
        wait_to(e + 800);
        bus_read(A_PEEK, d, r); check("R9 held", d, 32'h0020_0000);

        // R9 disable at position 0, then resume
        do_reset();
        bus_write(A_CTRL, RUN | 32'd1, e);
        wait_to(e + 40);
        bus_write(A_CTRL, 32'd1, dd);
        wait_to(dd + 100);
        bus_read(A_PEEK, d, r); check("R9 immediate stop", d, 32'h0010_0000);
        bus_write(A_CTRL, RUN | 32'd1, e);
        wait_to(e + 1 + 48);
        bus_read(A_PEEK, d, r); check("R9 resume", d, 32'h0020_0001);

        // R5 period count wrap, limit 0
        do_reset();
        bus_write(A_CTRL, RUN, e);
        m_e = e; m_p = 0;
        wait_to(e + 1 + 16*4095);
        bus_read(A_PEEK, d, r); check("R5 count 4095", d, 32'hFFF0_0000);
        wait_to(e + 1 + 16*4097);
        bus_read(A_PEEK, d, r); check("R5 count wraps", d, 32'h0010_0000);

        // R1 reset while running
        do_reset();
        bus_read(A_PEEK, d, r); check("R1 reset mid run", d, 32'h0);
        bus_read(A_CTRL, d, r); check("R1 ctrl after reset", d, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule